// File: doc/BRIEF.md
# Multi-Lane Time-Shared FIR Filter

This block is a long finite impulse response filter that shares a few multipliers across many taps. Each accepted input sample is written into a circular delay line. The block then spends N/K cycles on the convolution: K multiply-accumulate lanes each cover a contiguous slice of N/K taps. When the last slice step is done, the lane sums are added together and the result is issued with a single-cycle valid strobe.

The coefficients sit in an on-chip tap store with four banks. A write port fills the banks before filtering starts. A two-bit bank select picks the bank for each output, and it is captured when the sample is accepted. An input strobe that arrives while a result is still being formed is dropped, and a busy flag reports this condition. Because the acceptance window includes the final compute cycle, a source that holds its strobe high gets one output every N/K cycles.

Top module: `fir_ps_engine`

## Requirements
- R1: While reset is low and after it is released, out_valid and busy are low. Every sample in the delay line is zero, so taps that reach back before the first accepted sample see zero.
- R2: A sample is accepted on a rising clock edge when in_valid is high and busy is low. In the cycle that follows an acceptance, busy is high.
- R3: The result for an accepted sample x[n] is the exact sum over j = 0..N-1 of h[b][j]·x[n-j], where x[n-j] is the sample accepted j acceptances earlier. The result is a signed value of width 2·DW+log2(N) and never wraps, including when every sample and every tap is −2^(DW−1).
- R4: out_valid goes high exactly N/K clock edges after the accepting edge and stays high for one cycle. out_data carries the result of R3 in that cycle.
- R5: busy is low during the final compute cycle. A sample offered in that cycle is accepted, so with in_valid held high, outputs follow one another every N/K cycles.
- R6: A strobe that arrives while busy is high is ignored. It produces no output and does not enter the delay line.
- R7: bank_sel is sampled at the accepting edge. Changing it during a computation has no effect on that result.
- R8: When tap_we is high at a clock edge, tap_wdata is stored at tap_waddr. The address is bank·N + j, where j is the tap index that multiplies the sample j acceptances old.
- R9: The delay line holds exactly the last N accepted samples. Once more than N samples have arrived, the oldest one no longer contributes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Sample strobe |
| in_sample | input | DW | Signed input sample |
| bank_sel | input | log2(BANKS) | Coefficient bank for the next accepted sample |
| tap_we | input | 1 | Tap store write enable |
| tap_waddr | input | log2(BANKS·N) | Tap store address, bank·N + tap index |
| tap_wdata | input | DW | Signed coefficient to store |
| out_valid | output | 1 | One-cycle result strobe |
| out_data | output | 2·DW+log2(N) | Signed filter result |
| busy | output | 1 | High while a new strobe would be ignored |

## Verification
The bench builds the block with N = 16 taps, K = 4 lanes, 18-bit data and four banks. Each output then takes four cycles, so a short run pushes well over N samples through the delay line and wraps the write pointer many times. These values also give every lane a distinct offset into both the sample ring and the tap bank. A bank filled entirely with the most negative value, fed with the most negative sample, drives the accumulator to its largest magnitude at this width. A stream with in_valid held high exercises back-to-back acceptance in the final cycle together with dropped strobes.

// File: rtl/fir_ps_engine.sv
module fir_ps_engine #(
  parameter int NTAPS = 256,
  parameter int LANES = 2,
  parameter int DW    = 18,
  parameter int BANKS = 4,
  localparam int SELW = $clog2(BANKS),
  localparam int TAW  = $clog2(BANKS * NTAPS),
  localparam int ACCW = 2 * DW + $clog2(NTAPS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  input  logic signed [DW-1:0]   in_sample,
  input  logic [SELW-1:0]        bank_sel,
  input  logic                   tap_we,
  input  logic [TAW-1:0]         tap_waddr,
  input  logic signed [DW-1:0]   tap_wdata,
  output logic                   out_valid,
  output logic signed [ACCW-1:0] out_data,
  output logic                   busy
);
  localparam int LEN = NTAPS / LANES;
  localparam int PW  = $clog2(NTAPS);
  localparam int IW  = $clog2(LEN);

  logic signed [DW-1:0]   smp [NTAPS];
  logic signed [DW-1:0]   tap [BANKS*NTAPS];
  logic [PW-1:0]          wptr, base;
  logic [IW-1:0]          idx;
  logic                   run;
  logic [SELW-1:0]        bank_r;
  logic signed [ACCW-1:0] acc      [LANES];
  logic signed [ACCW-1:0] lane_nxt [LANES];
  logic signed [ACCW-1:0] total;

  wire last   = run && (idx == IW'(LEN - 1));
  wire accept = in_valid && (!run || last);
  assign busy = run && !last;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [PW-1:0]          sa;
    logic [TAW-1:0]         ta;
    logic signed [2*DW-1:0] prod;
    assign sa   = base - PW'(k * LEN) - PW'(idx);
    assign ta   = TAW'(bank_r) * TAW'(NTAPS) + TAW'(k * LEN) + TAW'(idx);
    assign prod = smp[sa] * tap[ta];
    assign lane_nxt[k] = acc[k] + ACCW'(prod);
  end

  always_comb begin
    total = '0;
    for (int k = 0; k < LANES; k++) total = total + lane_nxt[k];
  end

  always_ff @(posedge clk) begin
    if (tap_we) tap[tap_waddr] <= tap_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr      <= '0;
      base      <= '0;
      idx       <= '0;
      run       <= 1'b0;
      bank_r    <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
      for (int k = 0; k < LANES; k++) acc[k] <= '0;
      for (int i = 0; i < NTAPS; i++) smp[i] <= '0;
    end else begin
      out_valid <= last;
      if (last) out_data <= total;
      if (accept) begin
        smp[wptr] <= in_sample;
        base      <= wptr;
        wptr      <= wptr + 1'b1;
        bank_r    <= bank_sel;
        idx       <= '0;
        run       <= 1'b1;
        for (int k = 0; k < LANES; k++) acc[k] <= '0;
      end else if (run) begin
        idx <= idx + 1'b1;
        for (int k = 0; k < LANES; k++) acc[k] <= lane_nxt[k];
        if (last) run <= 1'b0;
      end
    end
  end
endmodule

module fir_ps_engine_chk #(
  parameter int LEN = 128
) (
  input logic clk,
  input logic rst_n,
  input logic in_valid,
  input logic busy,
  input logic out_valid
);
  localparam int CW = $clog2(LEN) + 1;
  logic          run;
  logic [CW-1:0] cyc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= 1'b0;
      cyc <= '0;
    end else if (in_valid && !busy) begin
      run <= 1'b1;
      cyc <= '0;
    end else if (run && cyc == CW'(LEN - 1)) begin
      run <= 1'b0;
    end else if (run) begin
      cyc <= cyc + 1'b1;
    end
  end

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |=> (!out_valid && !busy));

  assert_accept_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !busy) |=> busy);

  assert_result_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cyc == CW'(LEN - 1)) |=> out_valid);

  assert_no_orphan_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(run && cyc == CW'(LEN - 1)));

  assert_single_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  assert_busy_only_running_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> run);
endmodule

bind fir_ps_engine fir_ps_engine_chk #(.LEN(NTAPS / LANES)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .busy(busy), .out_valid(out_valid)
);

// File: tb/sim_fir_ps_engine.sv
module sim_fir_ps_engine;
  localparam int CLK_PERIOD = 10;
  localparam int N = 16, K = 4, DW = 18, B = 4;
  localparam int LEN = N / K;
  localparam int SELW = $clog2(B), TAW = $clog2(B * N), ACCW = 2 * DW + $clog2(N);

  logic clk = 0, rst_n = 0, in_valid = 0, tap_we = 0;
  logic signed [DW-1:0] in_sample = '0, tap_wdata = '0;
  logic [SELW-1:0] bank_sel = '0;
  logic [TAW-1:0] tap_waddr = '0;
  logic out_valid, busy;
  logic signed [ACCW-1:0] out_data;

  fir_ps_engine #(.NTAPS(N), .LANES(K), .DW(DW), .BANKS(B)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
    .bank_sel(bank_sel), .tap_we(tap_we), .tap_waddr(tap_waddr), .tap_wdata(tap_wdata),
    .out_valid(out_valid), .out_data(out_data), .busy(busy));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0;
  int taps [B][N];
  logic signed [DW-1:0] hist [$];
  int cnt = 0;
  longint pend = 0;
  string tag = "R3";
  int last_out = -1, cyc_no = 0, gap_fail = 0;

  task automatic check(string req, longint act, longint exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, cyc_no);
    end
  endtask

  function automatic longint conv(int b);
    longint s = 0;
    for (int j = 0; j < hist.size(); j++) s += longint'(taps[b][j]) * longint'(hist[j]);
    return s;
  endfunction

  task automatic cyc(bit v, logic signed [DW-1:0] s, int b);
    bit acc_ok, ev;
    longint ed;
    in_valid = v; in_sample = s; bank_sel = SELW'(b);
    @(posedge clk); #1;
    cyc_no++;
    acc_ok = v && (cnt == 0 || cnt == 1);
    ev = (cnt == 1);
    ed = pend;
    if (acc_ok) begin
      hist.push_front(s);
      if (hist.size() > N) void'(hist.pop_back());
      pend = conv(b);
      cnt = LEN;
    end else if (cnt > 0) cnt--;
    check("R4 out_valid", longint'(out_valid), longint'(ev));
    check("R2 busy", longint'(busy), longint'(cnt > 1));
    if (ev && out_valid) check({tag, " out_data"}, longint'(out_data), ed);
    if (out_valid) last_out = cyc_no;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int b = 0; b < B; b++)
      for (int j = 0; j < N; j++)
        taps[b][j] = (b == 3) ? -131072 : ((b == 2 && j == 5) ? 131071 : ((j * 37 + b * 101) % 2001) - 1000);
    repeat (3) @(posedge clk);
    #1;
    // R1: quiet during reset
    check("R1 out_valid in reset", longint'(out_valid), 0);
    check("R1 busy in reset", longint'(busy), 0);
    rst_n = 1;
    @(posedge clk); #1;
    check("R1 out_valid after reset", longint'(out_valid), 0);
    check("R1 busy after reset", longint'(busy), 0);

    // R8: load every bank through the write port
    for (int b = 0; b < B; b++)
      for (int j = 0; j < N; j++) begin
        tap_we = 1; tap_waddr = TAW'(b * N + j); tap_wdata = DW'(taps[b][j]);
        @(posedge clk); #1;
      end
    tap_we = 0;

    // R1 R8: impulse on bank 0 reads the taps back in order, zeros before first sample
    tag = "R1/R8 impulse";
    cyc(1, 18'sd1, 0);
    for (int i = 0; i < N + 2; i++) begin
      repeat (LEN) cyc(0, 0, 0);
      cyc(1, 0, 0);
    end
    repeat (LEN + 2) cyc(0, 0, 0);

    // R5 R6: strobe held high, extra strobes dropped, fixed output spacing
    tag = "R5/R6 stream";
    for (int i = 0; i < 12 * LEN; i++) begin
      int prev = last_out;
      cyc(1, $signed(DW'($urandom)), 1);
      if (out_valid && prev > 0 && i > LEN) check("R5 output spacing", longint'(cyc_no - prev), longint'(LEN));
    end
    repeat (LEN + 2) cyc(0, 0, 1);

    // R7: bank changes while busy must not matter
    tag = "R7 bank hold";
    for (int i = 0; i < 10; i++) begin
      cyc(1, $signed(DW'($urandom)), i % B);
      for (int c = 0; c < LEN + (i % 3); c++) cyc(0, 0, (i + c + 1) % B);
    end

    // R3 R9: extreme values, full magnitude, more than N samples for wrap
    tag = "R3/R9 extreme";
    for (int i = 0; i < 2 * N + 3; i++) begin
      cyc(1, -18'sd131072, 3);
      repeat (LEN - 1 + (i % 2)) cyc(0, 0, 3);
    end
    repeat (LEN + 2) cyc(0, 0, 3);

    // R9: mixed banks and gaps over many pointer wraps
    tag = "R9 wrap";
    for (int i = 0; i < 5 * N; i++) begin
      cyc(1, $signed(DW'($urandom)), (i / 7) % B);
      repeat ($urandom_range(LEN + 3, 0)) cyc(0, 0, 0);
    end
    repeat (LEN + 2) cyc(0, 0, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule